// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

A synchronous front end for a 128K x 8 asynchronous static RAM with a low-true and a high-true chip select, low-true write and output strobes, and one shared 8-bit data bus. The host hands over single-beat reads and writes on a valid/ready request channel. The controller then plays out the pin sequence for each access. Every window is held for a whole number of clock cycles, derived at elaboration from the selected speed grade and the clock period.

The request channel follows valid/ready rules. A request moves on the rising edge where `req_valid` and `req_ready` are both high. The host must keep the request fields stable while `req_valid` is high and `req_ready` is low. The read-return channel has no back-pressure: `rd_valid` is a one-cycle pulse, and `rd_data` holds its value until the next pulse. A plain sleep handshake parks the RAM in retention standby and brings it back out. Leaving standby includes the required recovery delay.

The timing counts are derived as follows. Each nanosecond limit becomes `ceil(limit / CLK_NS)` cycles, never less than one. The write strobe stays low for the longest of the write pulse, chip-select-to-end, address-to-end and (bus release plus data setup) counts.

Top module: `asram_ctrl`

## Requirements
- R1: Reset behaviour. After reset, all of the following hold:
  - `req_ready` = 1, `rd_valid` = 0, `sleep_ack` = 0.
  - `ram_ce1_n` = 1, `ram_ce2` = 1, `ram_we_n` = 1, `ram_oe_n` = 1.
  - `ram_dq_oe` = 0.
- R2: Read accepted on edge k:
  - From edge k until edge k+T_ACC, the RAM is selected (`ram_ce1_n`=0, `ram_ce2`=1) with `ram_we_n`=1 and `ram_oe_n`=0. That is exactly T_ACC cycles of `ram_oe_n` low.
  - `ram_dq_in` is captured at edge k+T_ACC, and `rd_valid` is high for exactly the one cycle after that edge.
  - T_ACC is the larger of the access-time and read-cycle counts: 3 at 20 ns, grade 55.
- R3: After a read, `ram_oe_n` is high and the chip is deselected for T_TURN cycles before `req_ready` returns. `req_ready` is high again T_ACC+T_TURN cycles after the accepting edge (T_TURN = 1 at default).
- R4: Write accepted on edge k: `ram_we_n` is low with the chip selected and `ram_oe_n` high for exactly T_WLO cycles (3 at default).
- R5: Data driver (`ram_dq_oe`) timing:
  - It is high only while `ram_we_n` is low, the chip is selected and `ram_oe_n` is high.
  - It stays low for the first T_WOFF cycles of the write strobe, then stays high until the strobe ends.
  - This gives T_WLO−T_WOFF driven cycles, which is at least T_DS (2 driven cycles at default).
- R6: A write leaves the RAM deselected for T_WREC cycles (at least one) after the strobe. `req_ready` returns T_WLO+T_WREC cycles after the accepting edge.
- R7: `req_ready` is high only when the controller is idle and `sleep_req` is low. It drops for the cycle after every accepting edge.
- R8: `rd_data` changes only on the edge that raises `rd_valid`.
- R9: Entering sleep:
  - With `sleep_req` high in idle, the next edge enters retention: `ram_ce1_n`=1, `ram_ce2`=0, `sleep_ack`=1, `req_ready`=0.
  - Sleep takes priority over a simultaneous request, and no strobe falls while asleep.
- R10: Leaving sleep: the edge that samples `sleep_req` low raises `ram_ce2` and drops `sleep_ack`. `req_ready` returns T_WAKE cycles after that edge, where T_WAKE is the read-cycle count (3 at default).
- R11: A read returns the byte most recently written to the same address, at the lowest address (0) and the highest address (0x1FFFF) as well as others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle read-return strobe |
| rd_data | output | 8 | Read data, held between strobes |
| sleep_req | input | 1 | Request retention standby |
| sleep_ack | output | 1 | RAM is in retention standby |
| ram_addr | output | 17 | RAM address pins |
| ram_ce1_n | output | 1 | RAM chip enable, low-true |
| ram_ce2 | output | 1 | RAM chip enable, high-true |
| ram_we_n | output | 1 | RAM write strobe, low-true |
| ram_oe_n | output | 1 | RAM output enable, low-true |
| ram_dq_out | output | 8 | Data toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for ram_dq_out |
| ram_dq_in | input | 8 | Data from the RAM |

## Verification
Counting from the edge that accepts a request:
- For a read, `rd_valid` is due in the cycle after edge k+T_ACC, and `req_ready` after edge k+T_ACC+T_TURN.
- For a write, `req_ready` is due after edge k+T_WLO+T_WREC.
- After sleep release, `req_ready` is due T_WAKE edges later.

The bench samples on falling edges and numbers them from the accepting edge. The n-th falling edge sits in the cycle after edge k+n−1, so each result is compared at falling edge (due count + 1). Strobe-low and driver-on cycles are counted over the whole access rather than at a single point. The expected counts come from the bench's own ceiling-division of the nanosecond limits.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_RD_TURN, ST_WR, ST_WR_REC, ST_SLEEP, ST_WAKE
  } seq_state_e;

  // Timing limit selectors
  localparam int LIM_ACCESS  = 0;
  localparam int LIM_CYCLE   = 1;
  localparam int LIM_OE_OFF  = 2;
  localparam int LIM_WPULSE  = 3;
  localparam int LIM_CS_END  = 4;
  localparam int LIM_AD_END  = 5;
  localparam int LIM_DSETUP  = 6;
  localparam int LIM_WE_OFF  = 7;

  function automatic int lim_ns(input int grade, input int sel);
    int g;
    g = (grade < 0) ? 0 : (grade > 2) ? 2 : grade;
    case (sel)
      LIM_ACCESS, LIM_CYCLE: return (g == 0) ? 55 : (g == 1) ? 70 : 100;
      LIM_OE_OFF, LIM_WE_OFF: return (g == 0) ? 20 : (g == 1) ? 25 : 30;
      LIM_WPULSE: return (g == 0) ? 45 : (g == 1) ? 50 : 70;
      LIM_CS_END, LIM_AD_END: return (g == 0) ? 50 : (g == 1) ? 60 : 80;
      LIM_DSETUP: return (g == 0) ? 25 : (g == 1) ? 30 : 40;
      default: return 100;
    endcase
  endfunction

  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_delay_cnt.sv
module asram_delay_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] value,
  output logic             zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         value <= '0;
    else if (load)      value <= load_val;
    else if (value != 0) value <= value - 1'b1;
  end
  assign zero = (value == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int T_ACC  = 3,
  parameter int T_TURN = 1,
  parameter int T_WLO  = 3,
  parameter int T_WREC = 1,
  parameter int T_WAKE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_wr,
  input  logic             sleep_req,
  input  logic             cnt_zero,
  output seq_state_e       state,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             req_ready,
  output logic             accept,
  output logic             capture
);
  seq_state_e nxt;

  assign req_ready = (state == ST_IDLE) && !sleep_req;
  assign accept    = req_ready && req_valid;

  always_comb begin
    nxt      = state;
    cnt_load = 1'b0;
    cnt_val  = '0;
    capture  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (sleep_req) nxt = ST_SLEEP;
        else if (req_valid) begin
          cnt_load = 1'b1;
          if (req_wr) begin
            nxt = ST_WR;
            cnt_val = CNT_W'(T_WLO - 1);
          end else begin
            nxt = ST_RD;
            cnt_val = CNT_W'(T_ACC - 1);
          end
        end
      end
      ST_RD: if (cnt_zero) begin
        capture  = 1'b1;
        nxt      = ST_RD_TURN;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(T_TURN - 1);
      end
      ST_RD_TURN: if (cnt_zero) nxt = ST_IDLE;
      ST_WR: if (cnt_zero) begin
        nxt      = ST_WR_REC;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(T_WREC - 1);
      end
      ST_WR_REC: if (cnt_zero) nxt = ST_IDLE;
      ST_SLEEP: if (!sleep_req) begin
        nxt      = ST_WAKE;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(T_WAKE - 1);
      end
      ST_WAKE: if (cnt_zero) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter int T_WLO  = 3,
  parameter int T_WOFF = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ram_dq_in,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  output logic              ram_ce1_n,
  output logic              ram_ce2,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              sleep_ack
);
  localparam int DRV_LIM = T_WLO - T_WOFF;

  logic active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr   <= '0;
      ram_dq_out <= '0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      if (accept) begin
        ram_addr   <= req_addr;
        ram_dq_out <= req_wdata;
      end
      if (capture) rd_data <= ram_dq_in;
      rd_valid <= capture;
    end
  end

  assign active    = (state == ST_RD) || (state == ST_WR);
  assign ram_ce1_n = !active;
  assign ram_ce2   = (state != ST_SLEEP);
  assign ram_oe_n  = (state != ST_RD);
  assign ram_we_n  = (state != ST_WR);
  assign ram_dq_oe = (state == ST_WR) && (int'(cnt) < DRV_LIM);
  assign sleep_ack = (state == ST_SLEEP);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int CLK_NS = 20,
  parameter int GRADE  = 0,
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sleep_req,
  output logic              sleep_ack,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce1_n,
  output logic              ram_ce2,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);
  localparam int T_ACC  = imax(ns_to_cyc(lim_ns(GRADE, LIM_ACCESS), CLK_NS),
                               ns_to_cyc(lim_ns(GRADE, LIM_CYCLE), CLK_NS));
  localparam int T_TURN = ns_to_cyc(lim_ns(GRADE, LIM_OE_OFF), CLK_NS);
  localparam int T_WOFF = ns_to_cyc(lim_ns(GRADE, LIM_WE_OFF), CLK_NS);
  localparam int T_DS   = ns_to_cyc(lim_ns(GRADE, LIM_DSETUP), CLK_NS);
  localparam int T_WLO  = imax(imax(ns_to_cyc(lim_ns(GRADE, LIM_WPULSE), CLK_NS),
                                    ns_to_cyc(lim_ns(GRADE, LIM_CS_END), CLK_NS)),
                               imax(ns_to_cyc(lim_ns(GRADE, LIM_AD_END), CLK_NS),
                                    T_WOFF + T_DS));
  localparam int T_WREC = imax(1, ns_to_cyc(lim_ns(GRADE, LIM_CYCLE), CLK_NS) - T_WLO);
  localparam int T_WAKE = ns_to_cyc(lim_ns(GRADE, LIM_CYCLE), CLK_NS);
  localparam int T_MAX  = imax(imax(T_ACC, T_WLO), imax(T_WAKE, imax(T_TURN, T_WREC)));
  localparam int CNT_W  = $clog2(T_MAX + 1);

  seq_state_e       state;
  logic             cnt_load, cnt_zero, accept, capture;
  logic [CNT_W-1:0] cnt_val, cnt;

  asram_delay_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .value(cnt), .zero(cnt_zero)
  );

  asram_seq #(
    .CNT_W(CNT_W), .T_ACC(T_ACC), .T_TURN(T_TURN), .T_WLO(T_WLO),
    .T_WREC(T_WREC), .T_WAKE(T_WAKE)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .sleep_req(sleep_req), .cnt_zero(cnt_zero), .state(state),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .req_ready(req_ready),
    .accept(accept), .capture(capture)
  );

  asram_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .T_WLO(T_WLO), .T_WOFF(T_WOFF)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .state(state), .cnt(cnt), .accept(accept),
    .capture(capture), .req_addr(req_addr), .req_wdata(req_wdata),
    .ram_dq_in(ram_dq_in), .ram_addr(ram_addr), .ram_dq_out(ram_dq_out),
    .ram_dq_oe(ram_dq_oe), .ram_ce1_n(ram_ce1_n), .ram_ce2(ram_ce2),
    .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .rd_data(rd_data),
    .rd_valid(rd_valid), .sleep_ack(sleep_ack)
  );
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_wr,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              sleep_req,
  input logic              sleep_ack,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_ce1_n,
  input logic              ram_ce2,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic [DATA_W-1:0] ram_dq_out,
  input logic              ram_dq_oe,
  input logic [DATA_W-1:0] ram_dq_in
);
  // R5
  dq_drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> (!ram_we_n && !ram_ce1_n && ram_ce2 && ram_oe_n));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> ram_oe_n);

  // R2
  rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R7
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_ce1_n && ram_we_n && ram_oe_n && !sleep_req));

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> rd_valid);

  // R9
  sleep_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ack |-> (ram_ce1_n && !ram_ce2 && !req_ready && ram_we_n));
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;
  function automatic int cdiv(input int ns);
    int c;
    c = (ns + 19) / 20;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_ACC  = cdiv(55);
  localparam int E_TURN = cdiv(20);
  localparam int E_WOFF = cdiv(20);
  localparam int E_DS   = cdiv(25);
  localparam int E_WLO  = 3;
  localparam int E_WREC = 1;
  localparam int E_WAKE = cdiv(55);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0, sleep_req = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rd_valid, sleep_ack;
  logic [7:0] rd_data, ram_dq_out, ram_dq_in;
  logic [16:0] ram_addr;
  logic ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n, ram_dq_oe;

  int n_chk = 0, n_bad = 0;
  logic [7:0] ram_mem [int];
  logic [7:0] shadow  [int];

  always #10 clk = ~clk;

  asram_ctrl i_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sleep_req(sleep_req),
    .sleep_ack(sleep_ack), .ram_addr(ram_addr), .ram_ce1_n(ram_ce1_n),
    .ram_ce2(ram_ce2), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  // RAM model
  function automatic logic [7:0] mem_rd(input logic [16:0] a);
    if (ram_mem.exists(int'(a))) return ram_mem[int'(a)];
    return 8'h00;
  endfunction

  assign ram_dq_in = (!ram_ce1_n && ram_ce2 && ram_we_n && !ram_oe_n) ? mem_rd(ram_addr) : 8'h00;

  logic       in_wr = 1'b0;
  logic [7:0] wr_last = '0;
  logic [16:0] wr_at = '0;
  always @(negedge clk) begin
    if (!ram_ce1_n && ram_ce2 && !ram_we_n) begin
      in_wr <= 1'b1;
      wr_at <= ram_addr;
      if (ram_dq_oe) wr_last <= ram_dq_out;
    end else if (in_wr) begin
      in_wr <= 1'b0;
      ram_mem[int'(wr_at)] = wr_last;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int lo = 0, drv = 0, rv_at = 0, rdy_at = 0, sel_bad = 0;
    logic [7:0] got = '0;
    req_wr = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R7: ready drops after acceptance
    check(!req_ready, "R7", req_ready, 0);
    for (int n = 1; n <= 40; n++) begin
      if (wr ? !ram_we_n : !ram_oe_n) begin
        lo++;
        if (ram_ce1_n || !ram_ce2 || (wr && !ram_oe_n) || (!wr && !ram_we_n)) sel_bad++;
      end
      if (ram_dq_oe) drv++;
      if (rd_valid) begin rv_at = n; got = rd_data; end
      if (req_ready) begin rdy_at = n; break; end
      @(negedge clk);
    end
    if (wr) begin
      check(lo == E_WLO, "R4", lo, E_WLO);
      check(sel_bad == 0, "R4", sel_bad, 0);
      check(drv == E_WLO - E_WOFF && drv >= E_DS, "R5", drv, E_WLO - E_WOFF);
      check(rdy_at == E_WLO + E_WREC + 1, "R6", rdy_at, E_WLO + E_WREC + 1);
      shadow[int'(a)] = d;
    end else begin
      check(lo == E_ACC, "R2", lo, E_ACC);
      check(sel_bad == 0, "R2", sel_bad, 0);
      check(rv_at == E_ACC + 1, "R2", rv_at, E_ACC + 1);
      check(rdy_at == E_ACC + E_TURN + 1, "R3", rdy_at, E_ACC + E_TURN + 1);
      check(got == (shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00), "R11", got,
            shadow.exists(int'(a)) ? shadow[int'(a)] : 0);
      // R8: data held after the pulse
      check(rd_data == got, "R8", rd_data, got);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    logic [16:0] pool [8];
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready && !rd_valid && !sleep_ack, "R1", {req_ready, rd_valid, sleep_ack}, 3'b100);
    check(ram_ce1_n && ram_ce2 && ram_we_n && ram_oe_n && !ram_dq_oe, "R1",
          {ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n, ram_dq_oe}, 5'b11110);

    // Directed corners: address extremes (R11)
    do_op(1'b1, 17'h1FFFF, 8'hA5);
    do_op(1'b1, 17'h00000, 8'h5A);
    do_op(1'b0, 17'h1FFFF, 8'h00);
    do_op(1'b0, 17'h00000, 8'h00);
    do_op(1'b1, 17'h00000, 8'hFF);
    do_op(1'b0, 17'h00000, 8'h00);

    // R9: sleep wins over a simultaneous request
    req_wr = 1'b0; req_addr = 17'h1FFFF; req_valid = 1'b1; sleep_req = 1'b1;
    @(negedge clk);
    check(sleep_ack && ram_ce1_n && !ram_ce2 && !req_ready, "R9",
          {sleep_ack, ram_ce1_n, ram_ce2, req_ready}, 4'b1100);
    begin
      int strobes = 0;
      for (int i = 0; i < 5; i++) begin
        if (!ram_oe_n || !ram_we_n) strobes++;
        @(negedge clk);
      end
      check(strobes == 0, "R9", strobes, 0);
    end
    req_valid = 1'b0;
    sleep_req = 1'b0;
    begin
      int rdy_at = 0;
      @(negedge clk);
      // R10: standby left on the sampling edge
      check(ram_ce2 && !sleep_ack, "R10", {ram_ce2, sleep_ack}, 2'b10);
      for (int n = 1; n <= 20; n++) begin
        if (req_ready) begin rdy_at = n; break; end
        @(negedge clk);
      end
      check(rdy_at == E_WAKE + 1, "R10", rdy_at, E_WAKE + 1);
    end
    do_op(1'b0, 17'h1FFFF, 8'h00);

    // Constrained random mix
    for (int i = 0; i < 8; i++) pool[i] = (i == 0) ? 17'h0 : (i == 7) ? 17'h1FFFF : 17'($urandom);
    for (int i = 0; i < 80; i++) begin
      int unsigned r = $urandom;
      do_op(r[0], pool[r[3:1]], 8'(r >> 8));
      if (r[12:10] == 3'd0) @(negedge clk);
    end
    finish_run();
  end
endmodule